// File: doc/BRIEF.md
# Dual-Channel PS/2 Host Register Front End

This block is the processor-facing register layer for two PS/2 channels: channel 0 serves a keyboard and channel 1 a mouse. A simple synchronous bus (address, read strobe, write strobe, write byte, read byte) reaches both channels. Each channel has a 256-byte window and four word-spaced registers in that window. Each channel drives an external byte engine: it sends a transmit strobe with a byte, and it receives a not-empty flag, a head-of-queue byte with a pop strobe, and an interrupt level. The serial line engines and their queues sit outside this block.

Each channel holds a control byte. In loopback mode a transmitted byte never reaches the engine. Instead it is kept locally and can be read back as received data, and it raises the channel interrupt until software reads it. Diagnostic mode makes the two line-shadow status bits follow the programmed line directions. The block merges both channel interrupts onto one output and also shows the merged state in each status register.

Top module: `ps2_dual_regif`

## Requirements
- R1: Address bit 8 selects the channel (0 keyboard, 1 mouse) and bits [3:2] select the register. All other address bits are ignored. Register index 0 reads back the channel number (0 or 1).
- R2: Read data appears on `bus_rdata` in the cycle after the read strobe. In a cycle that follows no read strobe, `bus_rdata` is 0.
- R3: A write to index 2 replaces the whole control byte, and a read of index 2 returns it. A write to index 0 is accepted and changes nothing. Control bit 1 is loopback, bit 5 diagnostic, bit 6 data-line direction, bit 7 clock-line direction, and bit 0 is an enable bit that is only stored.
- R4: Without loopback, a write to index 1 raises `eng_tx_valid` for that channel alone, during the strobe cycle, with the written byte on that channel's lane of `eng_tx_byte`.
- R5: Without loopback, a read of index 1 raises that channel's `eng_rx_pop` for exactly the strobe cycle and returns the engine byte present at the strobe.
- R6: With loopback, a write to index 1 stores the byte, sets the channel's loopback-full flag and port interrupt, and produces no `eng_tx_valid`.
- R7: With loopback, a read of index 1 returns the stored byte, clears the loopback-full flag and the port interrupt, and produces no `eng_rx_pop`.
- R8: Status (index 3) bits 6 and 7 read 1 unless diagnostic mode is on. In diagnostic mode, bit 6 equals control bit 6 and bit 7 equals control bit 7.
- R9: Status bit 0 shows the loopback-full flag when loopback is on. Otherwise it shows that channel's `eng_rx_nempty`.
- R10: Status bit 4 is 1 while either channel's port interrupt is pending. Status bits 1, 2, 3 and 5 always read 0.
- R11: A channel's port interrupt is its loopback-full flag in loopback mode and its `eng_irq` level otherwise. `irq_o` is the OR of both channels' port interrupts.
- R12: After reset, control, the stored byte, the loopback-full flags, `bus_rdata` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 9 | Byte address; bit 8 selects the channel, bits [3:2] select the register |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Merged interrupt |
| eng_tx_valid | output | 2 | Per-channel transmit strobe |
| eng_tx_byte | output | 16 | Per-channel transmit byte, channel n on bits [8n+7:8n] |
| eng_rx_nempty | input | 2 | Per-channel engine receive not-empty |
| eng_rx_byte | input | 16 | Per-channel engine head-of-queue byte |
| eng_rx_pop | output | 2 | Per-channel pop strobe |
| eng_irq | input | 2 | Per-channel engine interrupt level |

## Verification
Directed sequences on each channel cover the ID read-back, a control overwrite followed by an ignored reset write, forwarding of transmit and pop, one full loopback store and drain, and all four diagnostic and direction combinations. Between them, these separate the loopback path from the engine path and the diagnostic mask from the default shadow value. A seeded random mix of control values, transmits, reads of every index and varying engine flags, bytes and interrupt levels then runs with garbage in the ignored address bits. This exposes wrong channel decoding, a leak between channels and a wrong interrupt source: the merged interrupt is checked on every access, and status bit 4 is checked against both channels at once.

// File: rtl/ps2rif_pkg.sv
package ps2rif_pkg;
  localparam int BYTE_W = 8;

  // register index, address bits [3:2]
  localparam logic [1:0] RIX_ID   = 2'd0;  // read: channel number; write: reset (ignored)
  localparam logic [1:0] RIX_DATA = 2'd1;  // read: receive byte; write: transmit byte
  localparam logic [1:0] RIX_CTRL = 2'd2;
  localparam logic [1:0] RIX_STAT = 2'd3;

  // control bit positions
  localparam int CB_LOOP = 1;
  localparam int CB_DIAG = 5;
  localparam int CB_DDIR = 6;
  localparam int CB_CDIR = 7;

  // status bit positions
  localparam int SB_RXNE = 0;
  localparam int SB_IRQ  = 4;
  localparam int SB_DSHD = 6;
  localparam int SB_CSHD = 7;
endpackage

// File: rtl/ps2rif_rst_sync.sv
module ps2rif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ps2rif_port.sv
module ps2rif_port
  import ps2rif_pkg::*;
#(
  parameter int PORT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              any_irq,
  input  logic              eng_nempty,
  input  logic [BYTE_W-1:0] eng_byte,
  input  logic              eng_irq,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_pop,
  output logic              port_irq,
  output logic [BYTE_W-1:0] rd_val
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] lb_byte_q, lb_byte_d;
  logic              lb_full_q, lb_full_d;
  logic              ctrl_en, byte_en, full_en;
  logic              loop_on, wr_tx, wr_ctrl, rd_rx;
  logic [BYTE_W-1:0] stat;

  assign loop_on = ctrl_q[CB_LOOP];
  assign wr_tx   = wr_en && (reg_sel == RIX_DATA);
  assign wr_ctrl = wr_en && (reg_sel == RIX_CTRL);
  assign rd_rx   = rd_en && (reg_sel == RIX_DATA);

  // next state
  always_comb begin
    ctrl_en   = wr_ctrl;
    ctrl_d    = wdata;
    byte_en   = wr_tx && loop_on;
    lb_byte_d = wdata;
    full_en   = (wr_tx || rd_rx) && loop_on;
    lb_full_d = wr_tx;  // a store in the same cycle as a drain wins
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      lb_byte_q <= '0;
      lb_full_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q    <= ctrl_d;
      if (byte_en) lb_byte_q <= lb_byte_d;
      if (full_en) lb_full_q <= lb_full_d;
    end
  end

  // engine side
  assign tx_valid = wr_tx && !loop_on;
  assign tx_byte  = tx_valid ? wdata : '0;
  assign rx_pop   = rd_rx && !loop_on;
  assign port_irq = loop_on ? lb_full_q : eng_irq;

  // status composition
  always_comb begin
    stat          = '0;
    stat[SB_DSHD] = 1'b1;
    stat[SB_CSHD] = 1'b1;
    if (ctrl_q[CB_DIAG]) begin
      stat[SB_DSHD] = ctrl_q[CB_DDIR];
      stat[SB_CSHD] = ctrl_q[CB_CDIR];
    end
    stat[SB_RXNE] = loop_on ? lb_full_q : eng_nempty;
    stat[SB_IRQ]  = any_irq;
  end

  // local read selection
  always_comb begin
    unique case (reg_sel)
      RIX_ID:   rd_val = BYTE_W'(PORT_ID);
      RIX_DATA: rd_val = loop_on ? lb_byte_q : eng_byte;
      RIX_CTRL: rd_val = ctrl_q;
      default:  rd_val = stat;
    endcase
  end
endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
  import ps2rif_pkg::*;
#(
  parameter int NPORT    = 2,
  parameter int SEL_W    = 1,
  parameter int WIN_BITS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WIN_BITS+SEL_W-1:0] bus_addr,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  output logic                      irq_o,
  output logic [NPORT-1:0]          eng_tx_valid,
  output logic [NPORT*BYTE_W-1:0]   eng_tx_byte,
  input  logic [NPORT-1:0]          eng_rx_nempty,
  input  logic [NPORT*BYTE_W-1:0]   eng_rx_byte,
  output logic [NPORT-1:0]          eng_rx_pop,
  input  logic [NPORT-1:0]          eng_irq
);
  logic              rst_n_s;
  logic [SEL_W-1:0]  port_sel;
  logic [1:0]        reg_sel;
  logic [NPORT-1:0]  port_irq;
  logic              any_irq;
  logic [BYTE_W-1:0] rd_val [NPORT];
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_q, rdata_d;

  ps2rif_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign port_sel = bus_addr[WIN_BITS +: SEL_W];
  assign reg_sel  = bus_addr[3:2];
  assign any_irq  = |port_irq;
  assign irq_o    = any_irq;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic hit;
    assign hit = (port_sel == SEL_W'(g));

    ps2rif_port #(.PORT_ID(g)) port_i (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .wr_en      (bus_wr && hit),
      .rd_en      (bus_rd && hit),
      .reg_sel    (reg_sel),
      .wdata      (bus_wdata),
      .any_irq    (any_irq),
      .eng_nempty (eng_rx_nempty[g]),
      .eng_byte   (eng_rx_byte[g*BYTE_W +: BYTE_W]),
      .eng_irq    (eng_irq[g]),
      .tx_valid   (eng_tx_valid[g]),
      .tx_byte    (eng_tx_byte[g*BYTE_W +: BYTE_W]),
      .rx_pop     (eng_rx_pop[g]),
      .port_irq   (port_irq[g]),
      .rd_val     (rd_val[g])
    );
  end

  // channel read mux; a channel number with no port reads 0
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (port_sel == SEL_W'(p)) rd_mux = rd_val[p];
    end
  end

  always_comb begin
    rdata_d = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ps2rif_chk.sv
module ps2rif_chk #(
  parameter int NPORT    = 2,
  parameter int SEL_W    = 1,
  parameter int WIN_BITS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [WIN_BITS+SEL_W-1:0] bus_addr,
  input logic                      bus_rd,
  input logic                      bus_wr,
  input logic [7:0]                bus_rdata,
  input logic [NPORT-1:0]          eng_tx_valid,
  input logic [NPORT-1:0]          eng_rx_pop
);
  // R5: a pop only comes from a receive-data read
  p_pop_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_rx_pop) |-> (bus_rd && bus_addr[3:2] == 2'd1));

  // R5: never more than one channel pops at once
  p_single_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_rx_pop));

  // R4: a transmit strobe only comes from a transmit write
  p_tx_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_tx_valid) |-> (bus_wr && bus_addr[3:2] == 2'd1));

  // R4: never more than one channel transmits at once
  p_single_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_tx_valid));

  // R2: no read strobe, zero read data next cycle
  p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 8'h00));

  // R10: reserved status bits stay 0
  p_stat_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[3:2] == 2'd3) |=> (bus_rdata[3:1] == 3'b000 && bus_rdata[5] == 1'b0));

  // R1: ID read returns the channel number from the address
  p_id_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[3:2] == 2'd0) |=>
      (bus_rdata == 8'($past(bus_addr[WIN_BITS +: SEL_W]))));
endmodule

bind ps2_dual_regif ps2rif_chk #(
  .NPORT(NPORT), .SEL_W(SEL_W), .WIN_BITS(WIN_BITS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_rdata    (bus_rdata),
  .eng_tx_valid (eng_tx_valid),
  .eng_rx_pop   (eng_rx_pop)
);

// File: tb/ps2_dual_regif_tb.sv
module ps2_dual_regif_tb_top;
  logic        clk;
  logic        rst_n;
  logic [8:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        irq_o;
  logic [1:0]  eng_tx_valid, eng_rx_nempty, eng_rx_pop, eng_irq;
  logic [15:0] eng_tx_byte, eng_rx_byte;

  int n_chk, n_fail;
  bit done;

  // bench model
  logic [7:0] m_ctrl [2];
  logic [7:0] m_lb   [2];
  logic       m_full [2];

  ps2_dual_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte), .eng_rx_nempty(eng_rx_nempty),
    .eng_rx_byte(eng_rx_byte), .eng_rx_pop(eng_rx_pop), .eng_irq(eng_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit m_loop(input int p);
    return m_ctrl[p][1];
  endfunction

  function automatic bit m_pirq(input int p);
    return m_loop(p) ? m_full[p] : eng_irq[p];
  endfunction

  function automatic logic [7:0] m_status(input int p);
    logic [7:0] s;
    s = 8'hC0;
    if (m_ctrl[p][5]) begin
      s[6] = m_ctrl[p][6];
      s[7] = m_ctrl[p][7];
    end
    s[0] = m_loop(p) ? m_full[p] : eng_rx_nempty[p];
    s[4] = m_pirq(0) | m_pirq(1);
    return s;
  endfunction

  function automatic logic [7:0] m_read(input int p, input int off);
    case (off)
      0:       return 8'(p);
      1:       return m_loop(p) ? m_lb[p] : eng_rx_byte[p*8 +: 8];
      2:       return m_ctrl[p];
      default: return m_status(p);
    endcase
  endfunction

  function automatic logic [8:0] mk_addr(input int p, input int off);
    logic [3:0] junk_hi;
    logic [1:0] junk_lo;
    junk_hi = 4'($urandom_range(0, 15));
    junk_lo = 2'($urandom_range(0, 3));
    return {p[0], junk_hi, off[1:0], junk_lo};
  endfunction

  task automatic chk_irq();
    logic e;
    e = m_pirq(0) | m_pirq(1);
    chk(irq_o == e, "R11 irq_o", irq_o, e);
  endtask

  task automatic do_write(input int p, input int off, input logic [7:0] v);
    @(negedge clk);
    bus_addr  = mk_addr(p, off);
    bus_wdata = v;
    bus_wr    = 1'b1;
    #5;
    chk_irq();
    for (int q = 0; q < 2; q++) begin
      logic ev;
      ev = (q == p) && (off == 1) && !m_loop(q);
      chk(eng_tx_valid[q] == ev, (off == 1 && m_loop(p)) ? "R6 no tx in loopback" : "R4 tx_valid",
          eng_tx_valid[q], ev);
      if (ev) chk(eng_tx_byte[q*8 +: 8] == v, "R4 tx_byte", eng_tx_byte[q*8 +: 8], v);
    end
    @(posedge clk);
    if (off == 2) m_ctrl[p] = v;
    if (off == 1 && m_loop(p)) begin
      m_lb[p]   = v;
      m_full[p] = 1'b1;
    end
    #1 bus_wr = 1'b0;
  endtask

  task automatic do_read(input int p, input int off, input string req);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = mk_addr(p, off);
    bus_rd   = 1'b1;
    #5;
    chk_irq();
    e = m_read(p, off);
    for (int q = 0; q < 2; q++) begin
      logic ep;
      ep = (q == p) && (off == 1) && !m_loop(q);
      chk(eng_rx_pop[q] == ep, (off == 1 && m_loop(p)) ? "R7 no pop in loopback" : "R5 rx_pop",
          eng_rx_pop[q], ep);
    end
    @(posedge clk);
    if (off == 1 && m_loop(p)) m_full[p] = 1'b0;
    #1 bus_rd = 1'b0;
    @(negedge clk);
    chk(bus_rdata == e, req, bus_rdata, e);
    #2;
    chk(eng_rx_pop == 2'b00, "R5 pop lasts one cycle", eng_rx_pop, 0);
    @(negedge clk);
    chk(bus_rdata == 8'h00, "R2 idle rdata", bus_rdata, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0; done = 1'b0;
    for (int p = 0; p < 2; p++) begin
      m_ctrl[p] = 8'h00; m_lb[p] = 8'h00; m_full[p] = 1'b0;
    end
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    eng_rx_nempty = 2'b00; eng_rx_byte = 16'h0000; eng_irq = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(bus_rdata == 8'h00, "R12 reset rdata", bus_rdata, 0);
    chk(irq_o == 1'b0, "R12 reset irq", irq_o, 0);
    for (int p = 0; p < 2; p++) begin
      do_read(p, 2, "R12 reset control");
      do_read(p, 3, "R12 reset status");
      do_read(p, 0, "R1 channel id");
    end

    // R3 control overwrite and ignored reset write
    do_write(0, 2, 8'h81);
    do_write(1, 2, 8'h21);
    do_read(0, 2, "R3 control readback ch0");
    do_read(1, 2, "R3 control readback ch1");
    do_write(0, 0, 8'hFF);
    do_write(1, 0, 8'h00);
    do_read(0, 2, "R3 reset write ignored ch0");
    do_read(1, 2, "R3 reset write ignored ch1");

    // R4 / R5 forwarding
    do_write(0, 2, 8'h00);
    do_write(1, 2, 8'h00);
    eng_rx_byte = 16'h5A3C; eng_rx_nempty = 2'b10;
    do_write(0, 1, 8'hED);
    do_write(1, 1, 8'hF4);
    do_read(0, 3, "R9 engine nempty ch0");
    do_read(1, 3, "R9 engine nempty ch1");
    do_read(0, 1, "R5 engine byte ch0");
    do_read(1, 1, "R5 engine byte ch1");
    eng_irq = 2'b10;
    do_read(0, 3, "R10 status irq from other channel");
    eng_irq = 2'b00;

    // R6 / R7 loopback
    do_write(1, 2, 8'h03);
    do_write(1, 1, 8'hA5);
    do_read(1, 3, "R9 loopback full status");
    do_read(0, 3, "R10 status irq seen on ch0");
    eng_rx_byte = 16'h0000;
    do_read(1, 1, "R7 loopback byte");
    do_read(1, 3, "R7 loopback drained status");
    do_write(1, 2, 8'h00);

    // R8 diagnostic combinations
    for (int k = 0; k < 4; k++) begin
      do_write(0, 2, {k[1], k[0], 6'h20});
      do_read(0, 3, "R8 diag shadow");
    end
    do_write(0, 2, 8'hC0);
    do_read(0, 3, "R8 shadow default");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int p, op;
      p  = $urandom_range(0, 1);
      op = $urandom_range(0, 9);
      eng_rx_nempty = 2'($urandom_range(0, 3));
      eng_irq       = 2'($urandom_range(0, 3));
      eng_rx_byte   = 16'($urandom);
      case (op)
        0:       do_write(p, 2, 8'($urandom) & 8'hE3);
        1:       do_write(p, 0, 8'($urandom));
        2, 3:    do_write(p, 1, 8'($urandom));
        4:       do_read(p, 0, "R1 random id");
        5, 6:    do_read(p, 1, "R5 R7 random data");
        7:       do_read(p, 2, "R3 random control");
        default: do_read(p, 3, "R8 R9 R10 random status");
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule